// File: doc/BRIEF.md
# Serial Flash Page Program Sequencer

This block is a host-side SPI master that writes one page of a serial flash through one of the device's two on-chip SRAM buffers. A single start pulse carries the target page number, the buffer choice and the number of bytes to send. The sequencer then runs three chip-select frames with no further help from the host.

The first frame loads the selected buffer from a byte stream. Each stream byte is taken with a one-cycle `dataTake` strobe. The second frame tells the device to commit that buffer to the chosen page, with or without its built-in erase. The third frame reads the status register again and again, keeping chip select low, until the ready bit is seen or a poll limit runs out. The block then releases chip select and pulses `done`. If the limit ran out, `error` is also set.

The SPI link runs in mode 0 and sends the most significant bit first. The half period of SCK is programmable. Between frames, chip select is held high for at least two SCK periods.

Top module: `flash_page_prog`

## Requirements
- R1: SCK is low whenever `csN` is high. MOSI changes only while SCK is low, and bytes go out most significant bit first. MISO is sampled on the rising SCK edge.
- R2: The first frame is the buffer-write opcode (0x84 when `bufSel`=0, 0x87 when `bufSel`=1), then three 0x00 address bytes, then `byteCount` stream bytes in stream order. Each stream byte is taken with one `dataTake` pulse.
- R3: The second frame is four bytes long. Its opcode is 0x88 (`bufSel`=0) or 0x89 (`bufSel`=1) when `eraseFirst`=0, and 0x83 or 0x86 when `eraseFirst`=1.
- R4: The second frame's three address bytes form a 24-bit word, sent high byte first. With `wideMode`=1 the page number sits in bits 20:9; with `wideMode`=0 it sits in bits 19:8. All other bits are 0.
- R5: The third frame is opcode 0xD7 followed by 0x00 dummy bytes, with `csN` low throughout. It ends after the first status byte whose bit 7 is 1, so a device that reports busy N times gives N+1 status bytes.
- R6: An SCK high phase lasts `sckDiv`+1 clock cycles. `csN` stays high for at least 4*(`sckDiv`+1) cycles between frames.
- R7: `busy` is high from the cycle after `start` until the end. `done` is a one-cycle pulse in the same cycle that `csN` rises at the end of the status frame, and `busy` falls in that cycle.
- R8: If `pollLimit` status bytes (at least one) all read busy, the frame ends, `done` pulses and `error` is set. `error` then holds until the next `start` clears it.
- R9: After reset, `csN`=1, `sck`=0, `busy`=0, `done`=0 and `error`=0.
- R10: With `byteCount`=0, the first frame carries only the opcode and the three address bytes, and no `dataTake` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; inputs below are latched with it |
| pageNum | input | 12 | Target page number |
| bufSel | input | 1 | SRAM buffer choice (0 or 1) |
| eraseFirst | input | 1 | Use the program opcode with built-in erase |
| wideMode | input | 1 | 1: 264-byte page layout, 0: 256-byte layout |
| byteCount | input | 9 | Number of stream bytes to load into the buffer |
| sckDiv | input | 8 | SCK half period minus one, in clock cycles |
| pollLimit | input | 16 | Maximum number of status bytes to read |
| dataIn | input | 8 | Current stream byte |
| dataTake | output | 1 | Pulse: `dataIn` taken, present the next byte |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Poll limit reached without ready |

## Verification
Frame content is known only when a frame finishes, and `done` arrives one status byte plus one cycle after the last ready bit is sampled. The bench therefore waits for the `done` pulse at falling clock edges, waits a further 100 cycles, and only then compares the logged frames. `busy` and the clearing of `error` are due in the register stage right after the start edge, so they are sampled at the next falling edge. SCK high time and chip-select gaps are counted in clock cycles by a counter that advances on the falling clock edge, so each one can be compared exactly with `sckDiv`+1 and 4*(`sckDiv`+1).

// File: rtl/fpp_pkg.sv
package fpp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_HDR,
    S_WR_DATA,
    S_PG_HDR,
    S_ST_CMD,
    S_ST_POLL
  } seq_state_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic       load;        // start shifting txByte (drops chip select)
    logic       csRelease;   // raise chip select and time the gap
    logic [7:0] txByte;
  } spi_ctl_t;

  localparam logic [7:0] OP_STATUS   = 8'hD7;
  localparam int         ADDR_W      = 24;
  localparam int         WIDE_SHIFT  = 9;
  localparam int         NARROW_SHIFT = 8;

  function automatic logic [7:0] bufWriteOp(input logic sel);
    return sel ? 8'h87 : 8'h84;
  endfunction

  function automatic logic [7:0] commitOp(input logic sel, input logic withErase);
    if (withErase) return sel ? 8'h86 : 8'h83;
    return sel ? 8'h89 : 8'h88;
  endfunction

endpackage

// File: rtl/fpp_spi_datapath.sv
module fpp_spi_datapath
  import fpp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  spi_ctl_t         ctl,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             miso,
  output logic             csN,
  output logic             sck,
  output logic             mosi,
  output logic             byteDone,
  output logic [7:0]       rxByte,
  output logic             linkIdle
);

  localparam int GAP_HALVES = 4;               // two SCK periods
  localparam int GAP_W      = $clog2(GAP_HALVES);
  localparam int BIT_W      = 3;

  logic [DIV_W-1:0] divCnt;
  logic             active;
  logic             gapping;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic [BIT_W-1:0] bitIdx;
  logic [GAP_W-1:0] gapIdx;
  logic             halfTick;

  assign halfTick = (active || gapping) && (divCnt == halfDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sck      <= 1'b0;
      active   <= 1'b0;
      gapping  <= 1'b0;
      divCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      bitIdx   <= '0;
      gapIdx   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.load) begin
        csN     <= 1'b0;
        sck     <= 1'b0;
        txShift <= ctl.txByte;
        bitIdx  <= '0;
        active  <= 1'b1;
        divCnt  <= '0;
      end else if (ctl.csRelease) begin
        csN     <= 1'b1;
        gapping <= 1'b1;
        gapIdx  <= '0;
        divCnt  <= '0;
      end else if (active || gapping) begin
        if (halfTick) begin
          divCnt <= '0;
          if (active) begin
            if (!sck) begin
              sck     <= 1'b1;
              rxShift <= {rxShift[6:0], miso};
            end else begin
              sck <= 1'b0;
              if (bitIdx == BIT_W'(7)) begin
                active   <= 1'b0;
                byteDone <= 1'b1;
              end else begin
                bitIdx  <= bitIdx + BIT_W'(1);
                txShift <= {txShift[6:0], 1'b0};
              end
            end
          end else begin
            if (gapIdx == GAP_W'(GAP_HALVES - 1)) gapping <= 1'b0;
            else gapIdx <= gapIdx + GAP_W'(1);
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign mosi     = txShift[7];
  assign rxByte   = rxShift;
  assign linkIdle = !active && !gapping;

endmodule

// File: rtl/fpp_sequencer.sv
module fpp_sequencer
  import fpp_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 9,
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              bufSel,
  input  logic              eraseFirst,
  input  logic              wideMode,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [DIV_W-1:0]  sckDiv,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [7:0]        dataIn,
  input  logic              byteDone,
  input  logic [7:0]        rxByte,
  input  logic              linkIdle,
  output spi_ctl_t          ctl,
  output logic [DIV_W-1:0]  divLatched,
  output logic              dataTake,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam int HDR_LAST = 3;

  seq_state_e        state;
  logic              pending;
  logic [CNT_W-1:0]  idx;
  logic [POLL_W-1:0] pollCnt;
  logic [PAGE_W-1:0] pageR;
  logic              bufR, eraseR, wideR;
  logic [CNT_W-1:0]  cntR;
  logic [POLL_W-1:0] limitR;

  logic              lastHdr, lastData, pollReady, pollOut, relNow;
  logic [ADDR_W-1:0] pageAddr;

  always_comb begin
    pageAddr  = wideR ? (ADDR_W'(pageR) << WIDE_SHIFT) : (ADDR_W'(pageR) << NARROW_SHIFT);
    lastHdr   = (idx == CNT_W'(HDR_LAST));
    lastData  = (idx == cntR - CNT_W'(1));
    pollReady = rxByte[7];
    pollOut   = (({1'b0, pollCnt} + (POLL_W+1)'(1)) >= {1'b0, limitR});
    relNow    = 1'b0;
    if (byteDone) begin
      unique case (state)
        S_WR_HDR:  relNow = lastHdr && (cntR == '0);
        S_WR_DATA: relNow = lastData;
        S_PG_HDR:  relNow = lastHdr;
        S_ST_POLL: relNow = pollReady || pollOut;
        default:   relNow = 1'b0;
      endcase
    end

    ctl.txByte = 8'h00;
    unique case (state)
      S_WR_HDR:  ctl.txByte = (idx == '0) ? bufWriteOp(bufR) : 8'h00;
      S_WR_DATA: ctl.txByte = dataIn;
      S_PG_HDR: begin
        unique case (idx[1:0])
          2'd0:    ctl.txByte = commitOp(bufR, eraseR);
          2'd1:    ctl.txByte = pageAddr[23:16];
          2'd2:    ctl.txByte = pageAddr[15:8];
          default: ctl.txByte = pageAddr[7:0];
        endcase
      end
      S_ST_CMD:  ctl.txByte = OP_STATUS;
      default:   ctl.txByte = 8'h00;
    endcase
    ctl.load      = pending && linkIdle && (state != S_IDLE);
    ctl.csRelease = relNow;
  end

  assign dataTake = ctl.load && (state == S_WR_DATA);
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pending    <= 1'b0;
      idx        <= '0;
      pollCnt    <= '0;
      pageR      <= '0;
      bufR       <= 1'b0;
      eraseR     <= 1'b0;
      wideR      <= 1'b0;
      cntR       <= '0;
      limitR     <= '0;
      divLatched <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) pending <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          pageR      <= pageNum;
          bufR       <= bufSel;
          eraseR     <= eraseFirst;
          wideR      <= wideMode;
          cntR       <= byteCount;
          limitR     <= pollLimit;
          divLatched <= sckDiv;
          error      <= 1'b0;
          idx        <= '0;
          pending    <= 1'b1;
          state      <= S_WR_HDR;
        end
        S_WR_HDR: if (byteDone) begin
          pending <= 1'b1;
          if (!lastHdr) idx <= idx + CNT_W'(1);
          else begin
            idx   <= '0;
            state <= (cntR == '0) ? S_PG_HDR : S_WR_DATA;
          end
        end
        S_WR_DATA: if (byteDone) begin
          pending <= 1'b1;
          if (lastData) begin
            idx   <= '0;
            state <= S_PG_HDR;
          end else idx <= idx + CNT_W'(1);
        end
        S_PG_HDR: if (byteDone) begin
          pending <= 1'b1;
          if (lastHdr) begin
            idx   <= '0;
            state <= S_ST_CMD;
          end else idx <= idx + CNT_W'(1);
        end
        S_ST_CMD: if (byteDone) begin
          pending <= 1'b1;
          pollCnt <= '0;
          state   <= S_ST_POLL;
        end
        S_ST_POLL: if (byteDone) begin
          if (pollReady || pollOut) begin
            done  <= 1'b1;
            error <= !pollReady;
            state <= S_IDLE;
          end else begin
            pollCnt <= pollCnt + POLL_W'(1);
            pending <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpp_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int CNT_W  = 9,
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic              bufSel,
  input  logic              eraseFirst,
  input  logic              wideMode,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [DIV_W-1:0]  sckDiv,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [7:0]        dataIn,
  output logic              dataTake,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              error
);

  spi_ctl_t         ctl;
  logic [DIV_W-1:0] divLatched;
  logic             byteDone;
  logic [7:0]       rxByte;
  logic             linkIdle;

  fpp_sequencer #(
    .PAGE_W(PAGE_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .POLL_W(POLL_W)
  ) i_seq (
    .clk(clk), .rstN(rstN), .start(start), .pageNum(pageNum), .bufSel(bufSel),
    .eraseFirst(eraseFirst), .wideMode(wideMode), .byteCount(byteCount),
    .sckDiv(sckDiv), .pollLimit(pollLimit), .dataIn(dataIn),
    .byteDone(byteDone), .rxByte(rxByte), .linkIdle(linkIdle),
    .ctl(ctl), .divLatched(divLatched), .dataTake(dataTake),
    .busy(busy), .done(done), .error(error)
  );

  fpp_spi_datapath #(.DIV_W(DIV_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .halfDiv(divLatched), .miso(miso),
    .csN(csN), .sck(sck), .mosi(mosi), .byteDone(byteDone),
    .rxByte(rxByte), .linkIdle(linkIdle)
  );

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sck,
  input logic             mosi,
  input logic             done,
  input logic             error,
  input logic [DIV_W-1:0] divNow
);

  localparam int HI_W = 16;
  logic [HI_W-1:0] hiCnt;

  // cycles csN has been high; saturates, starts saturated after reset
  always_ff @(posedge clk) begin
    if (!rstN) hiCnt <= '1;
    else if (!csN) hiCnt <= '0;
    else if (hiCnt != '1) hiCnt <= hiCnt + HI_W'(1);
  end

  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  a_r1_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> ({2'b00, hiCnt} >= (18'(divNow) + 18'd1) * 18'd4));

  a_r7_done_at_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

endmodule

bind flash_page_prog fpp_checker #(.DIV_W(DIV_W)) i_fpp_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
  .done(done), .error(error), .divNow(divLatched)
);

// File: tb/test_flash_page_prog.sv
module test_flash_page_prog;

  typedef struct packed {
    logic [11:0] page;
    logic        bufB;
    logic        erase;
    logic        wide;
    logic [8:0]  cnt;
    logic [7:0]  div;
    logic [7:0]  busyN;
    logic [15:0] limit;
    logic [7:0]  seed;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{12'h123, 1'b0, 1'b0, 1'b1, 9'd5, 8'd1, 8'd2, 16'd10,  8'h11},
    '{12'hFFF, 1'b1, 1'b1, 1'b0, 9'd3, 8'd0, 8'd0, 16'd4,   8'hA0},
    '{12'h001, 1'b1, 1'b0, 1'b1, 9'd8, 8'd2, 8'd5, 16'd100, 8'h3C},
    '{12'hA5C, 1'b0, 1'b1, 1'b0, 9'd1, 8'd3, 8'd1, 16'd2,   8'h7E},
    '{12'h800, 1'b0, 1'b0, 1'b0, 9'd0, 8'd0, 8'd0, 16'd1,   8'h00},
    '{12'h055, 1'b1, 1'b1, 1'b1, 9'd2, 8'd1, 8'd9, 16'd3,   8'h5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [11:0] pageNum = '0;
  logic bufSel = 1'b0, eraseFirst = 1'b0, wideMode = 1'b0;
  logic [8:0] byteCount = '0;
  logic [7:0] sckDiv = '0;
  logic [15:0] pollLimit = '0;
  logic [7:0] dataIn;
  logic dataTake, csN, sck, mosi, busy, done, error;
  logic miso = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  flash_page_prog i_flash_page_prog (
    .clk(clk), .rstN(rstN), .start(start), .pageNum(pageNum), .bufSel(bufSel),
    .eraseFirst(eraseFirst), .wideMode(wideMode), .byteCount(byteCount),
    .sckDiv(sckDiv), .pollLimit(pollLimit), .dataIn(dataIn), .dataTake(dataTake),
    .csN(csN), .sck(sck), .mosi(mosi), .miso(miso),
    .busy(busy), .done(done), .error(error)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  always @(negedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // byte stream source
  int dataIdx = 0;
  logic [7:0] seed = '0;
  assign dataIn = seed + 8'(dataIdx * 7);
  always @(posedge clk) if (dataTake) dataIdx <= dataIdx + 1;

  // flash device model
  int busyN = 0;
  int curDiv = 0;
  int frameIdx = -1;
  int bitCnt = 0;
  logic [7:0] shIn = '0, outReg = '0;
  logic [7:0] hd [0:7][0:3];
  int len [0:7];
  logic [31:0] hsh [0:7];
  int sckRise = 0, hiBad = 0, gapBad = 0, csRiseCyc = 0;

  always @(negedge csN) begin
    if (frameIdx >= 0 && (cyc - csRiseCyc) < 4 * (curDiv + 1)) gapBad++;
    frameIdx++;
    if (frameIdx >= 0 && frameIdx < 8) begin
      len[frameIdx] = 0;
      hsh[frameIdx] = '0;
      for (int k = 0; k < 4; k++) hd[frameIdx][k] = 8'hEE;
    end
    bitCnt = 0;
    miso = 1'b0;
  end

  always @(posedge csN) csRiseCyc = cyc;

  always @(posedge sck) if (!csN) begin
    sckRise = cyc;
    shIn = {shIn[6:0], mosi};
    bitCnt++;
    if (bitCnt == 8) begin
      bitCnt = 0;
      if (frameIdx >= 0 && frameIdx < 8) begin
        if (len[frameIdx] < 4) hd[frameIdx][len[frameIdx]] = shIn;
        else hsh[frameIdx] = hsh[frameIdx] * 32'd31 + {24'b0, shIn};
        len[frameIdx]++;
      end
    end
  end

  always @(negedge sck) if (!csN) begin
    if (cyc - sckRise != curDiv + 1) hiBad++;
    if (bitCnt == 0) begin
      outReg = 8'h00;
      if (frameIdx >= 0 && frameIdx < 8 && len[frameIdx] >= 1 && hd[frameIdx][0] == 8'hD7)
        outReg = ((len[frameIdx] - 1) < busyN) ? 8'h1C : 8'h9C;
      miso = outReg[7];
    end else begin
      miso = outReg[7 - bitCnt];
    end
  end

  task automatic runOp(input vec_t v);
    logic [7:0] expWr, expPg;
    logic [23:0] expAddr;
    logic [31:0] expHash;
    int lim, expStat, waited;
    logic expErr;
    expWr = v.bufB ? 8'h87 : 8'h84;
    expPg = v.erase ? (v.bufB ? 8'h86 : 8'h83) : (v.bufB ? 8'h89 : 8'h88);
    expAddr = v.wide ? (24'(v.page) << 9) : (24'(v.page) << 8);
    expHash = '0;
    for (int k = 0; k < int'(v.cnt); k++) expHash = expHash * 32'd31 + {24'b0, v.seed + 8'(k * 7)};
    lim = (v.limit == 0) ? 1 : int'(v.limit);
    expErr = (int'(v.busyN) >= lim);
    expStat = expErr ? lim : int'(v.busyN) + 1;

    @(negedge clk);
    pageNum = v.page; bufSel = v.bufB; eraseFirst = v.erase; wideMode = v.wide;
    byteCount = v.cnt; sckDiv = v.div; pollLimit = v.limit;
    seed = v.seed; dataIdx = 0; busyN = int'(v.busyN); curDiv = int'(v.div);
    frameIdx = -1; hiBad = 0; gapBad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", 32'(busy), 32'd1);
    chk("R8 error cleared by start", 32'(error), 32'd0);
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk("R7 done pulse seen", 32'(done), 32'd1);
    chk("R7 busy low with done", 32'(busy), 32'd0);
    repeat (100) @(negedge clk);
    chk("R5 frame count", 32'(frameIdx + 1), 32'd3);
    chk("R2 write opcode", 32'(hd[0][0]), 32'(expWr));
    chk("R2 write zero address", {8'h0, hd[0][1], hd[0][2], hd[0][3]}, 32'd0);
    chk("R2 R10 write frame length", 32'(len[0]), 32'(4 + int'(v.cnt)));
    chk("R2 stream order", expHash, hsh[0]);
    chk("R2 R10 dataTake count", 32'(dataIdx), 32'(v.cnt));
    chk("R3 program opcode", 32'(hd[1][0]), 32'(expPg));
    chk("R3 program frame length", 32'(len[1]), 32'd4);
    chk("R4 page address", {8'h0, hd[1][1], hd[1][2], hd[1][3]}, {8'h0, expAddr});
    chk("R5 status opcode", 32'(hd[2][0]), 32'hD7);
    chk("R5 dummy byte", 32'(hd[2][1]), 32'h00);
    chk("R5 status byte count", 32'(len[2] - 1), 32'(expStat));
    chk("R8 error flag", 32'(error), 32'(expErr));
    chk("R1 R6 sck high time", 32'(hiBad), 32'd0);
    chk("R6 cs high gap", 32'(gapBad), 32'd0);
    chk("R1 sck low when idle", 32'(sck), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 csN after reset", 32'(csN), 32'd1);
    chk("R9 sck after reset", 32'(sck), 32'd0);
    chk("R9 busy after reset", 32'(busy), 32'd0);
    chk("R9 done after reset", 32'(done), 32'd0);
    chk("R9 error after reset", 32'(error), 32'd0);

    for (int i = 0; i < NVEC; i++) runOp(VECS[i]);

    // R8: error holds while idle after the timeout vector
    repeat (50) @(negedge clk);
    chk("R8 error sticky while idle", 32'(error), 32'd1);
    chk("R8 idle after timeout", 32'(busy), 32'd0);
    // next start clears it (checked inside runOp) and a clean run follows
    runOp(VECS[0]);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule